// File: doc/BRIEF.md
# Rotating Central Bus Arbiter with Forced Release

This block decides which requester owns a shared system bus. Four kinds of requester compete: a set of DMA channels, a memory refresh engine, a set of add-in bus masters and the host CPU. Each requester has one request input and one grant output. Ownership moves by a two-level rotation. The top level alternates between a fast group, holding the DMA channels and refresh, and a slow group, holding the bus masters and the CPU. Each group rotates round-robin inside itself, so a DMA channel never waits behind more than one slow-group tenure before its group is served again.

While a requester owns the bus and any other requester is waiting, the arbiter raises a single preempt output that tells the owner to finish and let go. A bus master that still holds its request a fixed number of clocks after preempt rose gets a one-clock pulse on its own reset output, and its grant is withdrawn in that same clock. DMA, refresh and CPU owners are never forced off. When nobody requests, the bus is parked on the CPU. Grants are registered, only one is ever active, and a new owner is granted only after at least one clock with no grant.

Top module: `rot_bus_arbiter`

## Requirements
- R1: At most one grant output is high in any clock.
- R2: When a grant goes away, the next different grant follows only after at least one clock in which no grant is high.
- R3: A DMA, refresh or bus-master grant is high in a clock only if that requester's request was high in the clock before.
- R4: The fast group is the DMA channels in ascending index followed by refresh; the slow group is the masters in ascending index followed by the CPU. When the bus is free, the group other than the one served last is preferred if it has a request, otherwise the other group is taken; after reset the fast group is preferred and each group starts at its lowest member. Inside a group the next requester after the one last served wins, wrapping around.
- R5: While any fast-group request is pending, at most one slow-group grant is issued before a fast-group grant.
- R6: With no request pending, the CPU grant is high (parking) one clock after the bus becomes free; a CPU request raised while parked keeps the grant high with no gap.
- R7: preempt rises one clock after another requester's request is seen while the bus is granted, and stays high until that grant ends, even if the waiting request is withdrawn.
- R8: When the owner drops its request, its grant and preempt are low in the next clock.
- R9: A bus master whose request is still high after preempt has been high for REL_TIMEOUT clocks gets a one-clock pulse on its reset output, and all grants are low in that clock.
- R10: A master that drops its request in the last clock of the preempt window receives no reset.
- R11: DMA, refresh and CPU owners are never reset and keep their grant for as long as they request, however long preempt stays high.
- R12: While rst_n is low, all grants, preempt and all master resets are low.
- R13: In the clock in which a master's reset pulse is high, that master is left out of the arbitration even if its request is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | N_DMA | Request from each DMA channel |
| dma_gnt | output | N_DMA | Grant to each DMA channel |
| rfsh_req | input | 1 | Request from the memory refresh engine |
| rfsh_gnt | output | 1 | Grant to the memory refresh engine |
| mst_req | input | N_MST | Request from each add-in bus master |
| mst_gnt | output | N_MST | Grant to each add-in bus master |
| cpu_req | input | 1 | Request from the host CPU |
| cpu_gnt | output | 1 | Grant to the host CPU, also high while parked |
| preempt | output | 1 | Tells the current owner to release the bus |
| mst_reset | output | N_MST | One-clock forced reset per bus master |

## Verification
The bench builds the arbiter with two DMA channels, two bus masters and a release timeout of 8 clocks, so the six requesters give only 63 non-empty request sets and every one of them is swept from reset with its complete grant order predicted from the alternation rule. The short timeout brings the preempt window within a few clocks, so the exact clock of the forced reset, release in the last window clock, sticky preempt after a withdrawn request and the exclusion of a master during its reset pulse are each reached directly. A continuous six-way contention run checks the rotation over two full rounds.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_PARK  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Round-robin selector: the first set request after position last, wrapping.
module arb_rr_pick #(
    parameter int W  = 3,
    parameter int IW = 2
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 1; k <= W; k++) begin
            int j;
            j = (int'(last) + k) % W;
            if (!any && req[j]) begin
                any = 1'b1;
                idx = IW'(j);
            end
        end
    end

endmodule

// File: rtl/arb_hold_timer.sv
// Counts clocks while run is high; expired marks the LIMIT-th such clock.
module arb_hold_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/rot_bus_arbiter.sv
module rot_bus_arbiter
    import arb_pkg::*;
#(
    parameter int N_DMA       = 2,
    parameter int N_MST       = 2,
    parameter int REL_TIMEOUT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DMA-1:0] dma_req,
    output logic [N_DMA-1:0] dma_gnt,
    input  logic             rfsh_req,
    output logic             rfsh_gnt,
    input  logic [N_MST-1:0] mst_req,
    output logic [N_MST-1:0] mst_gnt,
    input  logic             cpu_req,
    output logic             cpu_gnt,
    output logic             preempt,
    output logic [N_MST-1:0] mst_reset
);

    // Flat requester numbering: DMA 0..N_DMA-1, refresh, masters, CPU last.
    localparam int WA     = N_DMA + 1;
    localparam int WB     = N_MST + 1;
    localparam int NREQ   = WA + WB;
    localparam int IW     = $clog2(NREQ);
    localparam int AW     = (WA > 1) ? $clog2(WA) : 1;
    localparam int BW     = (WB > 1) ? $clog2(WB) : 1;
    localparam int MW     = (N_MST > 1) ? $clog2(N_MST) : 1;
    localparam int CPU_IX = NREQ - 1;

    typedef struct packed {
        arb_state_e       state;
        logic [IW-1:0]    owner;
        logic             turn_b;
        logic [AW-1:0]    last_a;
        logic [BW-1:0]    last_b;
        logic             preempt;
        logic [N_MST-1:0] mrst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NREQ-1:0] req_all;
    logic [NREQ-1:0] gnt_all;
    logic [NREQ-1:0] own_oh;
    logic [WB-1:0]   req_b;
    logic            a_any, b_any, take_b;
    logic [AW-1:0]   a_idx;
    logic [BW-1:0]   b_idx;
    logic            owner_req, others_pending, owner_is_mst;
    logic [MW-1:0]   mst_ix;
    logic            tmr_run, tmr_expired;

    assign req_all = {cpu_req, mst_req, rfsh_req, dma_req};
    // A master under forced reset sits out this round.
    assign req_b   = {cpu_req, mst_req & ~ctl_q.mrst};

    arb_rr_pick #(.W(WA), .IW(AW)) u_pick_fast (
        .req  (req_all[WA-1:0]),
        .last (ctl_q.last_a),
        .any  (a_any),
        .idx  (a_idx)
    );

    arb_rr_pick #(.W(WB), .IW(BW)) u_pick_slow (
        .req  (req_b),
        .last (ctl_q.last_b),
        .any  (b_any),
        .idx  (b_idx)
    );

    assign take_b = b_any && (ctl_q.turn_b || !a_any);

    assign tmr_run = (ctl_q.state == ST_GRANT) && ctl_q.preempt;

    arb_hold_timer #(.LIMIT(REL_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    always_comb begin
        own_oh = '0;
        own_oh[ctl_q.owner] = 1'b1;
    end

    assign owner_req      = |(req_all & own_oh);
    assign others_pending = |(req_all & ~own_oh);
    assign owner_is_mst   = (ctl_q.owner >= IW'(WA)) && (ctl_q.owner < IW'(CPU_IX));
    assign mst_ix         = MW'(ctl_q.owner - IW'(WA));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mrst = '0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.preempt = 1'b0;
                if (a_any || b_any) begin
                    ctl_d.state = ST_GRANT;
                    if (take_b) begin
                        ctl_d.owner  = IW'(WA) + IW'(b_idx);
                        ctl_d.last_b = b_idx;
                        ctl_d.turn_b = 1'b0;
                    end else begin
                        ctl_d.owner  = IW'(a_idx);
                        ctl_d.last_a = a_idx;
                        ctl_d.turn_b = 1'b1;
                    end
                end else begin
                    ctl_d.state = ST_PARK;
                end
            end
            ST_PARK: begin
                if (cpu_req) begin
                    ctl_d.state  = ST_GRANT;
                    ctl_d.owner  = IW'(CPU_IX);
                    ctl_d.last_b = BW'(WB - 1);
                    ctl_d.turn_b = 1'b0;
                end else if (|req_all) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_GRANT: begin
                if (!owner_req) begin
                    ctl_d.state   = ST_IDLE;
                    ctl_d.preempt = 1'b0;
                end else if (tmr_expired && owner_is_mst) begin
                    ctl_d.state        = ST_IDLE;
                    ctl_d.preempt      = 1'b0;
                    ctl_d.mrst[mst_ix] = 1'b1;
                end else begin
                    ctl_d.preempt = ctl_q.preempt | others_pending;
                end
            end
            default: begin
                ctl_d.state   = ST_IDLE;
                ctl_d.preempt = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.owner   <= '0;
            ctl_q.turn_b  <= 1'b0;
            ctl_q.last_a  <= AW'(WA - 1);
            ctl_q.last_b  <= BW'(WB - 1);
            ctl_q.preempt <= 1'b0;
            ctl_q.mrst    <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        gnt_all = '0;
        if (ctl_q.state == ST_GRANT) begin
            gnt_all = own_oh;
        end else if (ctl_q.state == ST_PARK) begin
            gnt_all[CPU_IX] = 1'b1;
        end
    end

    assign dma_gnt   = gnt_all[N_DMA-1:0];
    assign rfsh_gnt  = gnt_all[N_DMA];
    assign mst_gnt   = gnt_all[CPU_IX-1:WA];
    assign cpu_gnt   = gnt_all[CPU_IX];
    assign preempt   = ctl_q.preempt;
    assign mst_reset = ctl_q.mrst;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N_DMA = 2,
    parameter int N_MST = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_DMA+N_MST+1:0]     gnt_all,
    input logic [N_DMA+N_MST+1:0]     req_all,
    input logic                       preempt,
    input logic [N_MST-1:0]           mst_reset
);

    localparam int NREQ = N_DMA + N_MST + 2;
    localparam logic [NREQ-1:0] NONCPU = {1'b0, {(NREQ-1){1'b1}}};
    localparam logic [NREQ-1:0] MSTS   = {1'b0, {N_MST{1'b1}}, {(N_DMA+1){1'b0}}};
    localparam logic [NREQ-1:0] NOFORCE = ~MSTS;

    assert_one_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_all));

    assert_idle_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_all != '0) |=> (gnt_all == '0 || gnt_all == $past(gnt_all)));

    assert_gnt_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((gnt_all & ~$past(req_all) & NONCPU) == '0));

    assert_preempt_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> (gnt_all != '0));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_all & ~req_all & NONCPU) != '0) |=> (gnt_all == '0 && !preempt));

    assert_reset_after_preempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_reset != '0) |-> ($past(preempt) && gnt_all == '0 && $onehot(mst_reset)));

    assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_reset != '0) |=> (mst_reset == '0));

    assert_keep_unforced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_all & req_all & NOFORCE) != '0) |=> (gnt_all == $past(gnt_all)));

endmodule

bind rot_bus_arbiter arb_checker #(.N_DMA(N_DMA), .N_MST(N_MST)) u_arb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_all   (gnt_all),
    .req_all   (req_all),
    .preempt   (preempt),
    .mst_reset (mst_reset)
);

// File: tb/tb_rot_bus_arbiter.sv
module tb_rot_bus_arbiter;

    localparam int ND = 2;
    localparam int NM = 2;
    localparam int TO = 8;
    localparam int NR = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NR-1:0] rq;
    logic [ND-1:0] dma_gnt;
    logic          rfsh_gnt;
    logic [NM-1:0] mst_gnt;
    logic          cpu_gnt;
    logic          preempt;
    logic [NM-1:0] mst_reset;
    logic [NR-1:0] g;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    assign g = {cpu_gnt, mst_gnt, rfsh_gnt, dma_gnt};

    rot_bus_arbiter #(.N_DMA(ND), .N_MST(NM), .REL_TIMEOUT(TO)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_req   (rq[1:0]),
        .dma_gnt   (dma_gnt),
        .rfsh_req  (rq[2]),
        .rfsh_gnt  (rfsh_gnt),
        .mst_req   (rq[4:3]),
        .mst_gnt   (mst_gnt),
        .cpu_req   (rq[5]),
        .cpu_gnt   (cpu_gnt),
        .preempt   (preempt),
        .mst_reset (mst_reset)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [NR-1:0] pat);
        @(negedge clk);
        rst_n = 1'b0;
        rq    = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rq    = pat;
    endtask

    // Sweep one request set: every requester holds for one granted clock.
    task automatic sweep(input int p);
        int ord[NR];
        int ex[NR];
        int al[NR];
        int bl[NR];
        int n = 0, ne = 0, na = 0, nb = 0, ia = 0, ib = 0;
        int code_a = 0, code_e = 0;
        bit ta = 1'b1, bad = 1'b0, same;
        logic [NR-1:0] prev = '0;
        do_reset(NR'(p));
        for (int c = 0; c < 40 && rq != '0; c++) begin
            @(negedge clk);
            if ($countones(g) > 1) bad = 1'b1;
            if (prev != '0 && g != '0 && g != prev) bad = 1'b1;
            for (int i = 0; i < NR; i++) begin
                if (g[i] && rq[i]) begin
                    if (n < NR) ord[n] = i;
                    n++;
                    rq[i] = 1'b0;
                end
            end
            prev = g;
        end
        for (int i = 0; i < 3; i++) if (p[i]) begin al[na] = i; na++; end
        for (int i = 3; i < 6; i++) if (p[i]) begin bl[nb] = i; nb++; end
        while (ia < na || ib < nb) begin
            if ((ta && ia < na) || ib >= nb) begin
                ex[ne] = al[ia]; ia++; ta = 1'b0;
            end else begin
                ex[ne] = bl[ib]; ib++; ta = 1'b1;
            end
            ne++;
        end
        same = (n == ne);
        for (int k = 0; k < NR; k++) begin
            if (k < n && k < NR) code_a = code_a * 8 + ord[k] + 1;
            if (k < ne) code_e = code_e * 8 + ex[k] + 1;
            if (k < ne && k < n && ord[k] != ex[k]) same = 1'b0;
        end
        chk(!bad, $sformatf("R1 R2 sweep set %0d", p), int'(bad), 0);
        chk(same, $sformatf("R4 R5 order set %0d", p), code_a, code_e);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int np;
        bit seen_rst;
        logic [NR-1:0] pend;
        int k;

        rst_n = 1'b0;
        rq    = '0;
        repeat (3) @(negedge clk);
        chk(g == '0 && !preempt && mst_reset == '0, "R12 reset state",
            int'({mst_reset, preempt, g}), 0);

        // Exhaustive request sets
        for (int p = 1; p < 64; p++) sweep(p);

        // Parking, CPU ownership, preempt, release
        do_reset('0);
        @(negedge clk);
        chk(g == 6'd32, "R6 park on CPU", int'(g), 32);
        rq[5] = 1'b1;
        @(negedge clk);
        chk(g == 6'd32 && !preempt, "R6 CPU request keeps grant", int'(g), 32);
        rq[0] = 1'b1;
        @(negedge clk);
        chk(preempt == 1'b1, "R7 preempt rises", int'(preempt), 1);
        repeat (3 * TO) @(negedge clk);
        chk(g == 6'd32 && preempt && mst_reset == '0, "R11 CPU never forced",
            int'(g), 32);
        rq[5] = 1'b0;
        @(negedge clk);
        chk(g == '0 && !preempt, "R8 release drops grant", int'({preempt, g}), 0);
        @(negedge clk);
        chk(g == 6'd1, "R2 DMA after idle clock", int'(g), 1);
        rq[0] = 1'b0;

        // DMA owner held long under preempt
        do_reset(6'b000001);
        @(negedge clk);
        rq[3] = 1'b1;
        repeat (3 * TO) @(negedge clk);
        chk(g == 6'd1 && mst_reset == '0, "R11 DMA never forced", int'(g), 1);

        // Forced release of a master
        do_reset(6'b010000);
        @(negedge clk);
        chk(g == 6'd16, "R4 master granted", int'(g), 16);
        rq[0] = 1'b1;
        np = 0;
        for (int c = 0; c < 3 * TO; c++) begin
            @(negedge clk);
            if (mst_reset != '0) break;
            if (preempt) np++;
        end
        chk(np == TO, "R9 preempt window length", np, TO);
        chk(mst_reset == 2'b10 && g == '0, "R9 reset pulse on master 1",
            int'({mst_reset, g}), 128);
        rq[4] = 1'b0;
        @(negedge clk);
        chk(mst_reset == '0, "R9 reset lasts one clock", int'(mst_reset), 0);
        chk(g == 6'd1, "R9 waiting DMA served after reset", int'(g), 1);
        rq[0] = 1'b0;

        // Withdrawn waiter: sticky preempt, master excluded during reset
        do_reset(6'b010000);
        @(negedge clk);
        rq[0] = 1'b1;
        @(negedge clk);
        rq[0] = 1'b0;
        np = preempt ? 1 : 0;
        for (int c = 0; c < 3 * TO; c++) begin
            @(negedge clk);
            if (mst_reset != '0) break;
            if (preempt) np++;
        end
        chk(np == TO, "R7 preempt stays after withdrawal", np, TO);
        chk(mst_reset == 2'b10, "R9 reset after sticky preempt", int'(mst_reset), 2);
        @(negedge clk);
        chk(g == 6'd32, "R13 reset master skipped, bus parks", int'(g), 32);
        rq[4] = 1'b0;

        // Release in the last clock of the window
        do_reset(6'b010000);
        @(negedge clk);
        rq[3] = 1'b1;
        np = 0;
        for (int c = 0; c < 3 * TO && np < TO; c++) begin
            @(negedge clk);
            if (preempt) np++;
        end
        rq[4] = 1'b0;
        seen_rst = 1'b0;
        @(negedge clk);
        if (mst_reset != '0) seen_rst = 1'b1;
        chk(g == '0, "R10 grant dropped on release", int'(g), 0);
        @(negedge clk);
        if (mst_reset != '0) seen_rst = 1'b1;
        chk(g == 6'd8, "R10 waiting master follows", int'(g), 8);
        chk(!seen_rst, "R10 no reset on timely release", int'(seen_rst), 0);
        rq[3] = 1'b0;

        // Continuous six-way contention
        do_reset(6'b111111);
        pend = '0;
        k = 0;
        for (int c = 0; c < 200 && k < 12; c++) begin
            @(negedge clk);
            rq   = rq | pend;
            pend = '0;
            for (int i = 0; i < NR; i++) begin
                if (g[i] && rq[i] && k < 12) begin
                    int e;
                    e = ((k % 2) == 0) ? ((k / 2) % 3) : (3 + (k / 2) % 3);
                    chk(i == e, $sformatf("R4 R5 continuous grant %0d", k), i, e);
                    k++;
                    rq[i]   = 1'b0;
                    pend[i] = 1'b1;
                end
            end
        end
        chk(k == 12, "R4 continuous grant count", k, 12);
        rq = '0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule